// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page table entries for a memory management unit. A lookup presents a 32-bit virtual address together with the kind of access (load, store or instruction fetch) and the privilege of the requester. In the same cycle, with no clock edge in between, the block answers whether the page is held. On a hit it also returns the physical address, built from the stored physical page number and the untouched page offset, and raises a fault flag when the stored permissions forbid the access.

On a miss nothing is translated. The requester fetches the entry elsewhere, usually through a table walker or a software handler, and then writes the whole entry through the fill port. The contents are arranged as 16 sets of 4 ways. The set is picked by the low bits of the virtual page number, and the rest of the page number is kept as a tag. A fill goes to an empty way if the set has one. A full set evicts a victim chosen by a round-robin pointer kept for each set. A single pulse on the invalidate input empties the whole structure.

Top module: `tlb_top`

## Requirements
- R1: The virtual address splits into page offset VA[11:0], set index VA[15:12] and tag VA[31:16]. Pages that share an index but differ in tag are held side by side in that set.
- R2: A lookup that hits returns, combinationally, lk_hit=1 and lk_pa = {stored page number, VA[11:0]}.
- R3: A lookup that misses returns lk_hit=0, lk_pa=0 and lk_fault=0, whatever the access type.
- R4: The permission field uses bit0 read, bit1 write, bit2 execute and bit3 user-accessible. The access code is 0 load, 1 store, 2 fetch and 3 reserved. On a hit, lk_fault=1 when the bit that the access needs is clear, when lk_user=1 and the user bit is clear, or when the code is 3.
- R5: A fill is written on the rising clock edge, so a lookup of that page hits from the next cycle on.
- R6: A fill into a set that has an invalid way uses the lowest-numbered invalid way and evicts nothing. Four distinct tags in one set therefore all stay resident.
- R7: A fill into a full set evicts the way named by that set's round-robin pointer, then advances the pointer by one modulo 4. The pointer is way 0 after reset.
- R8: A fill whose tag is already held in its set overwrites that way in place. It evicts nothing and leaves the round-robin pointer unchanged.
- R9: inv_all clears every entry on one clock edge and overrides a fill in the same cycle.
- R10: While rst_n is low at a clock edge, all entries become invalid and all pointers return to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_va | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access code: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_user | input | 1 | Lookup comes from user privilege |
| lk_hit | output | 1 | Translation found |
| lk_pa | output | 32 | Physical address on a hit, zero otherwise |
| lk_fault | output | 1 | Permission violation on a hit |
| fill_en | input | 1 | Write an entry this cycle |
| fill_vpn | input | 20 | Virtual page number of the entry |
| fill_ppn | input | 20 | Physical page number of the entry |
| fill_perm | input | 4 | Permission bits of the entry |
| inv_all | input | 1 | Clear all entries |

## Verification
Lookups are tried against entries that differ only in tag within one set, against entries in different sets, and at several offsets within one page. This separates errors in the index and tag split from errors in the offset path. Five and then six fills into one set show which way the pointer evicts. A refill of a resident tag, followed by one more fill, shows that overwriting in place does not move the pointer. The permission cases combine each access code with user and supervisor privilege against entries that have single bits cleared, and store lookups that miss confirm that a miss never faults.

// File: rtl/tlb_pkg.sv
// Package tlb_pkg
// Shared encodings for the translation cache: access codes and the
// positions of the permission bits inside a stored entry.
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int PERM_W   = 4;
    localparam int PB_READ  = 0;
    localparam int PB_WRITE = 1;
    localparam int PB_EXEC  = 2;
    localparam int PB_USER  = 3;
endpackage

// File: rtl/tlb_way_match.sv
// Module tlb_way_match
// Compares one tag against the tags of all ways of a set and reports
// which valid way holds it. Assumes the set never holds a tag twice,
// so at most one way matches.
module tlb_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  valid,
    input  logic [TAG_W-1:0] tags [WAYS],
    input  logic [TAG_W-1:0] tag,
    output logic [WAYS-1:0]  match,
    output logic             hit,
    output logic [WAY_W-1:0] way
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    // Collapse the match vector into a hit flag and a way index.
    always_comb begin
        hit = |match;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) way = WAY_W'(w);
        end
    end

    // R8: refills overwrite in place, so duplicates never appear.
    a_r8_match_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_victim_sel.sv
// Module tlb_victim_sel
// Picks the way a fill writes. A resident copy of the tag wins. After
// that comes the lowest invalid way, and after that the round-robin
// pointer of the set. Assumes WAYS is a power of two.
module tlb_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  valid,
    input  logic             dup_hit,
    input  logic [WAY_W-1:0] dup_way,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] way,
    output logic             use_rr
);
    logic             any_free;
    logic [WAY_W-1:0] free_way;

    // Find the lowest-numbered invalid way.
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    // Order of preference: the resident tag, then a free way, then the pointer.
    always_comb begin
        use_rr = 1'b0;
        if (dup_hit)       way = dup_way;
        else if (any_free) way = free_way;
        else begin
            way    = rr_ptr;
            use_rr = 1'b1;
        end
    end

    // R6: with no resident copy and room in the set, no valid way is chosen.
    a_r6_fill_free_way: assert property (@(posedge clk) disable iff (!rst_n)
        (!dup_hit && !(&valid)) |-> !valid[way]);
endmodule

// File: rtl/tlb_perm_check.sv
// Module tlb_perm_check
// Checks the permission bits of a hitting entry against the access code
// and the privilege of the requester. It never flags a miss.
module tlb_perm_check
    import tlb_pkg::*;
(
    input  logic              hit,
    input  logic [PERM_W-1:0] perm,
    input  logic [1:0]        acc,
    input  logic              user,
    output logic              fault
);
    logic need_ok;

    // Choose the permission bit that this access needs.
    always_comb begin
        unique case (acc_e'(acc))
            ACC_LOAD:  need_ok = perm[PB_READ];
            ACC_STORE: need_ok = perm[PB_WRITE];
            ACC_FETCH: need_ok = perm[PB_EXEC];
            default:   need_ok = 1'b0;
        endcase
    end

    // Raise a fault on a hit when the needed bit or the user bit is missing.
    always_comb begin
        fault = hit && (!need_ok || (user && !perm[PB_USER]));
    end
endmodule

// File: rtl/tlb_top.sv
// Module tlb_top
// Set-associative translation cache. The lookup path is combinational.
// Fills and invalidate-all are written on the clock edge, and
// invalidate-all wins over a fill in the same cycle. Assumes SETS and
// WAYS are powers of two.
module tlb_top
    import tlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int VPN_W = VA_W - OFF_W,
    localparam int TAG_W = VPN_W - IDX_W,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [1:0]        lk_acc,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_fault,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_all
);
    // Entry storage: valid bits and pointers are reset, the payload is not.
    logic [WAYS-1:0]   vld_q  [SETS];
    logic [WAY_W-1:0]  rr_q   [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [PPN_W-1:0]  ppn_q  [SETS][WAYS];
    logic [PERM_W-1:0] perm_q [SETS][WAYS];

    // Address fields.
    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] lk_tag, fill_tag;
    logic [VPN_W-1:0] lk_vpn;
    assign lk_vpn   = lk_va[VA_W-1:OFF_W];
    assign lk_idx   = lk_vpn[IDX_W-1:0];
    assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

    // Bring out the tags of the set each port addresses.
    logic [TAG_W-1:0] lk_tags   [WAYS];
    logic [TAG_W-1:0] fill_tags [WAYS];
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_tags[w]   = tag_q[lk_idx][w];
            fill_tags[w] = tag_q[fill_idx][w];
        end
    end

    // Lookup match.
    logic [WAYS-1:0]  lk_match;
    logic [WAY_W-1:0] lk_way;
    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n),
        .valid(vld_q[lk_idx]), .tags(lk_tags), .tag(lk_tag),
        .match(lk_match), .hit(lk_hit), .way(lk_way)
    );

    // Fill-side match, used to find a resident copy of the tag.
    logic [WAYS-1:0]  fill_match;
    logic             fill_dup;
    logic [WAY_W-1:0] fill_dup_way;
    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
        .clk(clk), .rst_n(rst_n),
        .valid(vld_q[fill_idx]), .tags(fill_tags), .tag(fill_tag),
        .match(fill_match), .hit(fill_dup), .way(fill_dup_way)
    );

    // Victim choice for the fill.
    logic [WAY_W-1:0] fill_way;
    logic             fill_use_rr;
    tlb_victim_sel #(.WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .valid(vld_q[fill_idx]), .dup_hit(fill_dup), .dup_way(fill_dup_way),
        .rr_ptr(rr_q[fill_idx]), .way(fill_way), .use_rr(fill_use_rr)
    );

    // Permission check on the hitting entry.
    tlb_perm_check u_perm (
        .hit(lk_hit), .perm(perm_q[lk_idx][lk_way]),
        .acc(lk_acc), .user(lk_user), .fault(lk_fault)
    );

    // Form the physical address from the page number and the offset.
    always_comb begin
        lk_pa = lk_hit ? {ppn_q[lk_idx][lk_way], lk_va[OFF_W-1:0]} : '0;
    end

    logic fill_go;
    assign fill_go = fill_en && !inv_all;

    // Valid bits and pointers: reset, invalidate-all, or a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (inv_all) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (fill_en) begin
            vld_q[fill_idx][fill_way] <= 1'b1;
            if (fill_use_rr) rr_q[fill_idx] <= rr_q[fill_idx] + 1'b1;
        end
    end

    // Entry payload: written only by an accepted fill.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[fill_idx][fill_way]  <= fill_tag;
            ppn_q[fill_idx][fill_way]  <= fill_ppn;
            perm_q[fill_idx][fill_way] <= fill_perm;
        end
    end

    // R9: after invalidate-all nothing hits.
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !lk_hit);

    // R5: a filled page hits on the next cycle if the lookup stays on it.
    a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && (fill_vpn == lk_vpn)) |=> ($stable(lk_vpn) -> lk_hit));

    // R7: an eviction through the pointer advances that set's pointer by one.
    a_r7_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && fill_use_rr) |=>
        (rr_q[$past(fill_idx)] == WAY_W'($past(rr_q[fill_idx]) + 1'b1)));

    // R3: a fault never appears without a hit.
    a_r3_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);
endmodule

// File: tb/tlb_top_tb.sv
// Directed bench for tlb_top: one task per scenario, each checking its results.
module tlb_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_user = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        lk_fault;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_perm = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int failures = 0;

    localparam logic [3:0] P_R = 4'h1, P_W = 4'h2, P_X = 4'h4, P_U = 4'h8;
    localparam logic [3:0] P_ALL = 4'hF;

    always #2 clk = ~clk;

    tlb_top u_dut (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_acc(lk_acc),
        .lk_user(lk_user), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_fault(lk_fault),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .inv_all(inv_all)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                           input logic [3:0] perm);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] va,
                        input logic [1:0] acc, input logic user,
                        input logic exp_hit, input logic [31:0] exp_pa,
                        input logic exp_fault);
        @(negedge clk);
        lk_va = va; lk_acc = acc; lk_user = user;
        #1;
        chk(req, "hit", 32'(lk_hit), 32'(exp_hit));
        chk(req, "pa", lk_pa, exp_pa);
        chk(req, "fault", 32'(lk_fault), 32'(exp_fault));
    endtask

    // R10: nothing is held after reset.
    task automatic t_reset();
        look("R10", 32'h1234_5678, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        look("R10", 32'h0000_0000, 2'd1, 1'b0, 1'b0, 32'h0, 1'b0);
    endtask

    // R2 R5: a filled page translates at several offsets.
    task automatic t_hit();
        do_fill(20'h12345, 20'hABCDE, P_ALL);
        look("R5", 32'h1234_5678, 2'd0, 1'b0, 1'b1, 32'hABCD_E678, 1'b0);
        look("R2", 32'h1234_5000, 2'd2, 1'b1, 1'b1, 32'hABCD_E000, 1'b0);
        look("R2", 32'h1234_5FFF, 2'd1, 1'b0, 1'b1, 32'hABCD_EFFF, 1'b0);
    endtask

    // R1 R3: other sets and other tags miss; same-index tags coexist.
    task automatic t_split();
        look("R3", 32'h1234_6678, 2'd1, 1'b0, 1'b0, 32'h0, 1'b0);
        look("R1", 32'h2234_5678, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        do_fill(20'h22345, 20'h00111, P_R);
        look("R1", 32'h2234_5010, 2'd0, 1'b0, 1'b1, 32'h0011_1010, 1'b0);
        look("R1", 32'h1234_5010, 2'd0, 1'b0, 1'b1, 32'hABCD_E010, 1'b0);
    endtask

    // R4 R3: permission faults on hits, never on misses.
    task automatic t_perm();
        do_fill(20'h00003, 20'h00500, P_R);
        look("R4", 32'h0000_3004, 2'd0, 1'b0, 1'b1, 32'h0050_0004, 1'b0);
        look("R4", 32'h0000_3004, 2'd1, 1'b0, 1'b1, 32'h0050_0004, 1'b1);
        look("R4", 32'h0000_3004, 2'd2, 1'b0, 1'b1, 32'h0050_0004, 1'b1);
        look("R4", 32'h0000_3004, 2'd0, 1'b1, 1'b1, 32'h0050_0004, 1'b1);
        look("R4", 32'h0000_3004, 2'd3, 1'b0, 1'b1, 32'h0050_0004, 1'b1);
        do_fill(20'h00004, 20'h00600, P_W | P_X | P_U);
        look("R4", 32'h0000_4008, 2'd1, 1'b1, 1'b1, 32'h0060_0008, 1'b0);
        look("R4", 32'h0000_4008, 2'd2, 1'b1, 1'b1, 32'h0060_0008, 1'b0);
        look("R4", 32'h0000_4008, 2'd0, 1'b1, 1'b1, 32'h0060_0008, 1'b1);
        look("R3", 32'h0000_5008, 2'd1, 1'b1, 1'b0, 32'h0, 1'b0);
    endtask

    // R6 R7 R8: fill one set past capacity, then refill a resident tag.
    task automatic t_ways();
        for (int i = 1; i <= 4; i++)
            do_fill({16'(i * 4096), 4'hA}, 20'(32'h100 + i), P_ALL);
        for (int i = 1; i <= 4; i++)
            look("R6", {16'(i * 4096), 4'hA, 12'h020}, 2'd0, 1'b0, 1'b1,
                 {20'(32'h100 + i), 12'h020}, 1'b0);
        do_fill(20'h5000A, 20'h00105, P_ALL);
        look("R7", 32'h1000_A000, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        look("R7", 32'h5000_A000, 2'd0, 1'b0, 1'b1, 32'h0010_5000, 1'b0);
        look("R7", 32'h2000_A000, 2'd0, 1'b0, 1'b1, 32'h0010_2000, 1'b0);
        do_fill(20'h6000A, 20'h00106, P_ALL);
        look("R7", 32'h2000_A000, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        look("R7", 32'h3000_A000, 2'd0, 1'b0, 1'b1, 32'h0010_3000, 1'b0);
        do_fill(20'h4000A, 20'h00777, P_R);
        look("R8", 32'h4000_A0F0, 2'd0, 1'b0, 1'b1, 32'h0077_70F0, 1'b0);
        look("R8", 32'h3000_A000, 2'd0, 1'b0, 1'b1, 32'h0010_3000, 1'b0);
        look("R8", 32'h5000_A000, 2'd0, 1'b0, 1'b1, 32'h0010_5000, 1'b0);
        look("R8", 32'h6000_A000, 2'd0, 1'b0, 1'b1, 32'h0010_6000, 1'b0);
        do_fill(20'h7000A, 20'h00107, P_ALL);
        look("R8", 32'h3000_A000, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        look("R8", 32'h4000_A000, 2'd0, 1'b0, 1'b1, 32'h0077_7000, 1'b0);
    endtask

    // R9: invalidate-all empties everything and beats a fill in the same cycle.
    task automatic t_inv();
        @(negedge clk);
        inv_all = 1'b1; fill_en = 1'b1;
        fill_vpn = 20'h0BEEF; fill_ppn = 20'h00042; fill_perm = P_ALL;
        @(negedge clk);
        inv_all = 1'b0; fill_en = 1'b0;
        look("R9", 32'h0BEE_F000, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        look("R9", 32'h1234_5678, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        look("R9", 32'h7000_A000, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
        do_fill(20'h0BEEF, 20'h00042, P_ALL);
        look("R9", 32'h0BEE_F123, 2'd0, 1'b0, 1'b1, 32'h0004_2123, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_split();
        t_perm();
        t_ways();
        t_inv();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule